// File: doc/BRIEF.md
# Carry-Chain Unsigned Greater-Or-Equal Comparator

This block drives a single flag that is high when the unsigned operand `opa` is numerically no smaller than the unsigned operand `opb`. Both operands are `WIDTH` bits wide, with `WIDTH` at least 1. The block is purely combinational: it has no clock, no registers and no internal state. The answer appears after the gate delay of the logic path.

The logic is built from two generic primitive models: an N-input lookup table holding a truth-table constant, and a two-way carry multiplexer. The bottom two bit pairs are resolved together by one 4-input table. For wider operands, that result enters the bottom of a ripple chain. The chain has one carry multiplexer per remaining bit. Each of these is steered by a 2-input XNOR table: where the two operand bits match, the lower verdict passes upward unchanged; where they differ, the bit of `opa` is the verdict for that position.

A 1-bit instance uses a single 2-input table. A 2-bit instance uses only the 4-input table.

Top module: `cc_uge_compare`

## Requirements
- R1: For every `WIDTH` of at least 1 and all operand values, `ge_out` equals 1 exactly when `opa` is greater than or equal to `opb`, both taken as unsigned.
- R2: With `WIDTH` = 1, the result comes from a 2-input table with constant 4'hD, addressed as {opa[0], opb[0]}. Its output is 0 only for opa=0, opb=1.
- R3: With `WIDTH` of 2 or more, the low two bit pairs address a 4-input table with constant 16'hF731. The address is {opa[1], opa[0], opb[1], opb[0]}, most significant bit first, and the table gives (opa[1:0] >= opb[1:0]).
- R4: With `WIDTH` = 2, `ge_out` is the output of that 4-input table.
- R5: With `WIDTH` of 3 or more, the low-pair result selects a first carry multiplexer whose data input is 0 and whose carry input is 1. The chain seed therefore equals the low-pair verdict.
- R6: Each bit n from 2 upward has a 2-input XNOR table (constant 4'h9) on opa[n], opb[n] driving its multiplexer select. When the select is 1, the stage passes the stage below; when it is 0, the stage passes opa[n].
- R7: `ge_out` is the top stage's output, so the highest differing bit position decides the result regardless of the lower bits.
- R8: Equal operands give `ge_out` = 1 at every width.
- R9: `ge_out` follows a change on the operands with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Unsigned left operand |
| opb | input | WIDTH | Unsigned right operand |
| ge_out | output | 1 | High when opa >= opb |

## Verification
The hardest case to reach is one where the verdict must ripple through the whole chain. That requires every upper bit pair to match while the low pair alone decides. At 16 bits, random operands almost never produce this. The stimulus therefore copies the random upper bits of `opa` into `opb` and sweeps all sixteen low-pair combinations, so the seed has to travel unchanged to the output. A second pattern flips exactly one chosen upper bit, placing the deciding position at each stage in turn.

// File: rtl/cc_uge_pkg.sv
`timescale 1ns/1ps
package cc_uge_pkg;
    // 2-input table: zero only at address {a=0, b=1}
    parameter logic [3:0]  SINGLE_GE_INIT = 4'hD;
    // 2-input table: equality of the two address bits
    parameter logic [3:0]  PAIR_XNOR_INIT = 4'h9;
    // 4-input table over {a1, a0, b1, b0}: a[1:0] >= b[1:0]
    parameter logic [15:0] LOW_PAIR_INIT  = 16'hF731;
endpackage

// File: rtl/cc_uge_lut.sv
`timescale 1ns/1ps
module cc_uge_lut #(
    parameter int                        N_IN = 2,
    parameter logic [(1 << N_IN) - 1:0]  INIT = '0
) (
    input  logic [N_IN-1:0] addr,
    output logic            y
);
    // Generic truth-table primitive: output is the INIT bit at the address.
    assign y = INIT[addr];
endmodule

// File: rtl/cc_uge_cmux.sv
`timescale 1ns/1ps
module cc_uge_cmux (
    input  logic sel,
    input  logic di,
    input  logic ci,
    output logic co
);
    // Generic carry multiplexer: carry in when selected, local data otherwise.
    assign co = sel ? ci : di;
endmodule

// File: rtl/cc_uge_compare.sv
`timescale 1ns/1ps
module cc_uge_compare #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             ge_out
);
    import cc_uge_pkg::*;

    localparam int CW = (WIDTH > 2) ? WIDTH : 3;

    generate
        if (WIDTH == 1) begin : g_single
            cc_uge_lut #(.N_IN(2), .INIT(SINGLE_GE_INIT)) u_tab (
                .addr ({opa[0], opb[0]}),
                .y    (ge_out)
            );
            always_comb begin
                if (!$isunknown({opa, opb}))
                    a_r2_single_zero: assert (ge_out == !(opa[0] == 1'b0 && opb[0] == 1'b1));
            end
        end else begin : g_multi
            logic low_ge;

            cc_uge_lut #(.N_IN(4), .INIT(LOW_PAIR_INIT)) u_low (
                .addr ({opa[1], opa[0], opb[1], opb[0]}),
                .y    (low_ge)
            );

            always_comb begin
                if (!$isunknown({opa[1:0], opb[1:0]}))
                    a_r3_low_pair: assert (low_ge == (opa[1:0] >= opb[1:0]));
            end

            if (WIDTH == 2) begin : g_two
                assign ge_out = low_ge;
            end else begin : g_chain
                logic [CW-1:1] cy;

                cc_uge_cmux u_seed (
                    .sel (low_ge),
                    .di  (1'b0),
                    .ci  (1'b1),
                    .co  (cy[1])
                );

                always_comb begin
                    if (!$isunknown(low_ge))
                        a_r5_seed_follows: assert (cy[1] == low_ge);
                end

                for (genvar n = 2; n < WIDTH; n++) begin : g_stage
                    logic same;
                    cc_uge_lut #(.N_IN(2), .INIT(PAIR_XNOR_INIT)) u_xnor (
                        .addr ({opa[n], opb[n]}),
                        .y    (same)
                    );
                    cc_uge_cmux u_mux (
                        .sel (same),
                        .di  (opa[n]),
                        .ci  (cy[n-1]),
                        .co  (cy[n])
                    );
                    always_comb begin
                        if (!$isunknown({opa[n], opb[n], cy[n-1]})) begin
                            if (opa[n] != opb[n])
                                a_r6_differ_decides: assert (cy[n] == opa[n]);
                            else
                                a_r6_equal_passes: assert (cy[n] == cy[n-1]);
                        end
                    end
                end

                assign ge_out = cy[WIDTH-1];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown({opa, opb})) begin
            if (opa == opb)
                a_r8_equal_true: assert (ge_out == 1'b1);
            if (&opa)
                a_r7_top_all_ones: assert (ge_out == 1'b1);
            if (opa == '0 && opb != '0)
                a_r1_zero_below: assert (ge_out == 1'b0);
        end
    end
endmodule

// File: tb/test_cc_uge_compare.sv
`timescale 1ns/1ps
module test_cc_uge_compare;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [15:0] a_bus = '0;
    logic [15:0] b_bus = '0;
    logic g1, g2, g3, g4, g7, g16;

    cc_uge_compare #(.WIDTH(1))  i_cc_uge_compare_w1 (.opa(a_bus[0:0]), .opb(b_bus[0:0]), .ge_out(g1));
    cc_uge_compare #(.WIDTH(2))  i_cc_uge_compare_w2 (.opa(a_bus[1:0]), .opb(b_bus[1:0]), .ge_out(g2));
    cc_uge_compare #(.WIDTH(3))  i_cc_uge_compare_w3 (.opa(a_bus[2:0]), .opb(b_bus[2:0]), .ge_out(g3));
    cc_uge_compare #(.WIDTH(4))  i_cc_uge_compare_w4 (.opa(a_bus[3:0]), .opb(b_bus[3:0]), .ge_out(g4));
    cc_uge_compare #(.WIDTH(7))  i_cc_uge_compare_w7 (.opa(a_bus[6:0]), .opb(b_bus[6:0]), .ge_out(g7));
    cc_uge_compare #(.WIDTH(16)) i_cc_uge_compare    (.opa(a_bus),      .opb(b_bus),      .ge_out(g16));

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Behavioural reference: plain integer comparison of the low w bits.
    function automatic bit ref_ge(input int w, input logic [15:0] a, input logic [15:0] b);
        int ia, ib;
        ia = int'(a) % (1 << w);
        ib = int'(b) % (1 << w);
        return ia >= ib;
    endfunction

    function automatic string tag_of(input int w, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] m;
        m = 16'((32'd1 << w) - 1);
        if ((a & m) == (b & m)) return "R8";
        if (w == 1) return "R2";
        if (w == 2) return "R4";
        if (((a ^ b) & m & 16'hFFFC) != 0) return "R7";
        return "R5";
    endfunction

    task automatic chk_one(input int w, input logic got);
        bit exp;
        exp = ref_ge(w, a_bus, b_bus);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s/R1 width=%0d a=%h b=%h got=%b exp=%b",
                     tag_of(w, a_bus, b_bus), w, a_bus, b_bus, got, exp);
        end
    endtask

    task automatic check_all();
        chk_one(1, g1);  chk_one(2, g2);  chk_one(3, g3);
        chk_one(4, g4);  chk_one(7, g7);  chk_one(16, g16);
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        a_bus <= a;
        b_bus <= b;
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] ra, rb;
        // Initial state: both operands zero -> equal -> 1 (R8)
        @(negedge clk);
        check_all();

        // Exhaustive over the low 4 bits: widths 1..4 fully covered (R2, R3, R4)
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                apply(16'(i), 16'(j));

        // Extremes (R7, R8)
        apply(16'hFFFF, 16'hFFFF);
        apply(16'hFFFF, 16'h0000);
        apply(16'h0000, 16'hFFFF);
        apply(16'h0000, 16'h0000);
        apply(16'h8000, 16'h7FFF);
        apply(16'h7FFF, 16'h8000);

        // Matching upper bits, low pair decides across the whole chain (R5, R6)
        for (int k = 0; k < 40; k++) begin
            ra = 16'($urandom);
            for (int lp = 0; lp < 16; lp++)
                apply({ra[15:2], 2'(lp >> 2)}, {ra[15:2], 2'(lp & 3)});
        end

        // One differing upper bit at each stage, low bits adverse (R6, R7)
        for (int p = 2; p < 16; p++) begin
            ra = 16'($urandom);
            apply(ra | (16'd1 << p) | 16'h0000, (ra & ~(16'd1 << p)) | 16'h0003);
            apply((ra & ~(16'd1 << p)) & 16'hFFFC, ra | (16'd1 << p));
        end

        // Random operands, including forced equality (R1, R8)
        for (int k = 0; k < 1500; k++) begin
            ra = 16'($urandom);
            rb = (k % 7 == 0) ? ra : 16'($urandom);
            apply(ra, rb);
        end

        // R9: output follows operands mid-cycle, no clock edge between
        @(negedge clk);
        a_bus = 16'h0010;
        b_bus = 16'h0011;
        #1;
        check_all();
        a_bus = 16'h0012;
        #1;
        check_all();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule